// File: doc/BRIEF.md
# NaN Classify and Quieting Unit

This unit inspects one IEEE 754 double-precision operand on every clock cycle. It sorts the operand into one of six kinds: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. It also reports whether the operand is a NaN and whether that NaN is signaling.

A mode input selects which meaning the top fraction bit carries. In revised-standard mode, a clear top fraction bit marks a signaling NaN. In legacy mode, a set top fraction bit marks a signaling NaN.

When the caller requests quieting and the operand is a signaling NaN, the unit returns the quiet form of that NaN and raises a one-cycle invalid-operation flag. In every other case the operand passes through unchanged. All outputs are registered, so results appear one clock after their inputs.

Top module: `fpnan_unit`

## Requirements
- R1: `class_o` is one-hot and is registered from the operand. The bit positions are: bit0 zero (exponent 0, fraction 0), bit1 subnormal (exponent 0, fraction nonzero), bit2 normal (exponent neither 0 nor 0x7FF), bit3 infinity (exponent 0x7FF, fraction 0), bit4 quiet NaN, bit5 signaling NaN.
- R2: `is_nan_o` is 1 exactly when the exponent field (bits 62:52) is 0x7FF and the fraction (bits 51:0) is nonzero.
- R3: `is_snan_o` is 1 exactly for a NaN whose fraction bit 51 XOR `mode_2008_i` equals 1. With `mode_2008_i`=1 a clear bit 51 is signaling; with `mode_2008_i`=0 a set bit 51 is signaling.
- R4: In revised-standard mode (`mode_2008_i`=1), quieting a signaling NaN sets bit 51 and leaves every other bit as it was.
- R5: In legacy mode (`mode_2008_i`=0), quieting clears bit 51. If the fraction would then be all zero, bit 50 is also set, so the result remains a NaN.
- R6: `invalid_o` is 1 for one cycle exactly when `quiet_req_i` was 1 and the operand was a signaling NaN.
- R7: When no quieting takes place, `res_o` equals the operand and `invalid_o` stays 0. This covers `quiet_req_i`=0 as well as a request on a non-signaling value.
- R8: The sign bit (bit 63) of `res_o` always equals the sign of the operand.
- R9: All outputs are registered with one cycle of latency. While `rst_n` is low at a clock edge, every output is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 64 | Double-precision operand |
| mode_2008_i | input | 1 | 1 = revised-standard NaN convention, 0 = legacy convention |
| quiet_req_i | input | 1 | Request to quiet a signaling NaN |
| res_o | output | 64 | Quieted or passed-through value |
| class_o | output | 6 | One-hot class code |
| is_nan_o | output | 1 | Operand is a NaN |
| is_snan_o | output | 1 | Operand is a signaling NaN |
| invalid_o | output | 1 | Invalid-operation flag, one cycle wide |

## Verification
Directed operands cover one member of each of the six classes. Signaling NaNs are tried with only bit 51 or bit 50 set, so the legacy fix-up is told apart from a plain bit clear. A quiet NaN and an infinity are sent with the request high, which separates the signaling test from a plain NaN test. Random operands biased toward an all-ones exponent are run under both modes with the request toggled at random, so both polarities and the pass-through path are compared against bench-computed results.

// File: rtl/fpnan_pkg.sv
// Package: shared field widths and the one-hot class code for the NaN unit.
// Assumes the binary64 layout: sign, then exponent, then fraction, MSB first.
package fpnan_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int DATA_W = 1 + EXP_W + FRAC_W;
    localparam int QBIT   = FRAC_W - 1;   // quiet-indicator position
    localparam int NCLASS = 6;

    typedef enum logic [NCLASS-1:0] {
        CLS_ZERO = 6'b000001,
        CLS_SUB  = 6'b000010,
        CLS_NORM = 6'b000100,
        CLS_INF  = 6'b001000,
        CLS_QNAN = 6'b010000,
        CLS_SNAN = 6'b100000
    } fp_class_e;
endpackage

// File: rtl/fpnan_classify.sv
// Module: combinational classifier for one binary64 operand.
// Assumes mode_2008 = 1 means a clear quiet bit marks a signaling NaN.
module fpnan_classify
    import fpnan_pkg::*;
(
    input  logic [DATA_W-1:0] op,
    input  logic              mode_2008,
    output fp_class_e         cls,
    output logic              is_nan,
    output logic              is_snan
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones, exp_zero, frac_zero;

    // Field split and the basic exponent and fraction tests.
    always_comb begin
        exp_f     = op[DATA_W-2 -: EXP_W];
        frac_f    = op[FRAC_W-1:0];
        exp_ones  = &exp_f;
        exp_zero  = ~|exp_f;
        frac_zero = ~|frac_f;
    end

    // NaN and signaling decisions, then the class choice.
    always_comb begin
        is_nan  = exp_ones && !frac_zero;
        is_snan = is_nan && (frac_f[QBIT] ^ mode_2008);
        if (exp_zero)
            cls = frac_zero ? CLS_ZERO : CLS_SUB;
        else if (!exp_ones)
            cls = CLS_NORM;
        else if (frac_zero)
            cls = CLS_INF;
        else
            cls = is_snan ? CLS_SNAN : CLS_QNAN;
    end
endmodule

// File: rtl/fpnan_quiet.sv
// Module: turns a signaling NaN into a quiet NaN when asked.
// Assumes is_snan comes from the classifier under the same mode.
// The legacy path keeps the result a NaN by setting the next fraction bit.
module fpnan_quiet
    import fpnan_pkg::*;
(
    input  logic [DATA_W-1:0] op,
    input  logic              mode_2008,
    input  logic              is_snan,
    input  logic              req,
    output logic [DATA_W-1:0] res,
    output logic              invalid
);
    logic [DATA_W-1:0] q2008, qlegacy;

    // Candidate quiet values for each convention.
    always_comb begin
        q2008         = op;
        q2008[QBIT]   = 1'b1;
        qlegacy       = op;
        qlegacy[QBIT] = 1'b0;
        if (~|qlegacy[FRAC_W-1:0])
            qlegacy[QBIT-1] = 1'b1;
    end

    // Choose the quieted value or pass the operand through.
    always_comb begin
        invalid = req && is_snan;
        if (invalid)
            res = mode_2008 ? q2008 : qlegacy;
        else
            res = op;
    end
endmodule

// File: rtl/fpnan_unit.sv
// Module: top of the NaN classify and quieting unit, with one output register stage.
// Assumes a synchronous active-low reset. Every output has one cycle of latency.
module fpnan_unit
    import fpnan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       op_i,
    input  logic              mode_2008_i,
    input  logic              quiet_req_i,
    output logic [63:0]       res_o,
    output logic [5:0]        class_o,
    output logic              is_nan_o,
    output logic              is_snan_o,
    output logic              invalid_o
);
    fp_class_e         cls_c;
    logic              nan_c, snan_c, inv_c;
    logic [DATA_W-1:0] res_c;

    fpnan_classify u_cls (
        .op        (op_i),
        .mode_2008 (mode_2008_i),
        .cls       (cls_c),
        .is_nan    (nan_c),
        .is_snan   (snan_c)
    );

    fpnan_quiet u_qt (
        .op        (op_i),
        .mode_2008 (mode_2008_i),
        .is_snan   (snan_c),
        .req       (quiet_req_i),
        .res       (res_c),
        .invalid   (inv_c)
    );

    // Output register stage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o     <= '0;
            class_o   <= '0;
            is_nan_o  <= 1'b0;
            is_snan_o <= 1'b0;
            invalid_o <= 1'b0;
        end else begin
            res_o     <= res_c;
            class_o   <= cls_c;
            is_nan_o  <= nan_c;
            is_snan_o <= snan_c;
            invalid_o <= inv_c;
        end
    end

    // R1: the class code never has more than one bit set.
    p_class_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(class_o));
    // R3: a signaling indication always comes with a NaN indication.
    p_snan_is_nan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_snan_o |-> is_nan_o);
    // R6: the invalid flag is only raised for a signaling NaN.
    p_invalid_snan_r6: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> is_snan_o);
    // R5: a quieted result is still a NaN.
    p_quiet_stays_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> ((&res_o[62:52]) && (|res_o[51:0])));
    // R8: the sign passes through with one cycle of latency.
    p_sign_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_o[63] == $past(op_i[63])));
    // R7: without a flag, the result is the operand from the previous cycle.
    p_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !invalid_o) |-> (res_o == $past(op_i)));
endmodule

// File: tb/fpnan_unit_bench.sv
module fpnan_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_i = '0;
    logic        mode_2008_i = 1'b0;
    logic        quiet_req_i = 1'b0;
    logic [63:0] res_o;
    logic [5:0]  class_o;
    logic        is_nan_o, is_snan_o, invalid_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fpnan_unit u_fpnan_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .mode_2008_i(mode_2008_i),
        .quiet_req_i(quiet_req_i), .res_o(res_o), .class_o(class_o),
        .is_nan_o(is_nan_o), .is_snan_o(is_snan_o), .invalid_o(invalid_o)
    );

    function automatic bit f_nan(logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    endfunction

    function automatic bit f_snan(logic [63:0] v, bit m);
        return f_nan(v) && (v[51] ^ m);
    endfunction

    function automatic logic [5:0] f_class(logic [63:0] v, bit m);
        if (v[62:52] == 0) return (v[51:0] == 0) ? 6'b000001 : 6'b000010;
        if (v[62:52] != 11'h7FF) return 6'b000100;
        if (v[51:0] == 0) return 6'b001000;
        return f_snan(v, m) ? 6'b100000 : 6'b010000;
    endfunction

    function automatic logic [63:0] f_res(logic [63:0] v, bit m, bit q);
        logic [63:0] r;
        r = v;
        if (q && f_snan(v, m)) begin
            if (m) r[51] = 1'b1;
            else begin
                r[51] = 1'b0;
                if (r[51:0] == 0) r[50] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [63:0] v, bit m, bit q);
        @(negedge clk);
        op_i = v; mode_2008_i = m; quiet_req_i = q;
        @(negedge clk);
        chk("R1 class", {58'd0, class_o}, {58'd0, f_class(v, m)});
        chk("R2 is_nan", {63'd0, is_nan_o}, {63'd0, f_nan(v)});
        chk("R3 is_snan", {63'd0, is_snan_o}, {63'd0, f_snan(v, m)});
        chk(m ? "R4/R7/R8 result" : "R5/R7/R8 result", res_o, f_res(v, m, q));
        chk("R6/R7 invalid", {63'd0, invalid_o}, {63'd0, q && f_snan(v, m)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        void'($urandom(32'd20240611));
        op_i = 64'h7FF0_0000_0000_0001; quiet_req_i = 1'b1;
        repeat (3) @(negedge clk);
        // R9: reset clears every output
        chk("R9 reset res", res_o, 64'd0);
        chk("R9 reset flags", {56'd0, class_o, is_nan_o, is_snan_o}, 64'd0);
        chk("R9 reset invalid", {63'd0, invalid_o}, 64'd0);
        rst_n = 1'b1;
        // directed cases: one member of each class, in both modes
        for (int m = 0; m < 2; m++) begin
            apply(64'h0000_0000_0000_0000, m[0], 1'b1);
            apply(64'h8000_0000_0000_0000, m[0], 1'b1);
            apply(64'h0000_0000_0000_0001, m[0], 1'b1);
            apply(64'h3FF0_0000_0000_0000, m[0], 1'b1);
            apply(64'hFFF0_0000_0000_0000, m[0], 1'b1);
            apply(64'h7FF8_0000_0000_0000, m[0], 1'b1); // only bit 51 set
            apply(64'hFFF4_0000_0000_0000, m[0], 1'b1); // only bit 50 set
            apply(64'h7FF0_0000_0000_0001, m[0], 1'b1);
            apply(64'hFFFF_FFFF_FFFF_FFFF, m[0], 1'b1);
            apply(64'h7FF0_0000_0000_0001, m[0], 1'b0); // R7 no request
        end
        // R5 fix-up: legacy quieting of a NaN with only bit 51 set must give bit 50
        apply(64'hFFF8_0000_0000_0000, 1'b0, 1'b1);
        chk("R5 fixup", res_o, 64'hFFF4_0000_0000_0000);
        // random, biased toward an all-ones exponent
        for (int i = 0; i < 600; i++) begin
            v = {$urandom, $urandom};
            if ($urandom_range(0, 2) != 0) v[62:52] = 11'h7FF;
            if ($urandom_range(0, 3) == 0) v[50:0] = '0;
            apply(v, $urandom_range(0, 1), $urandom_range(0, 1));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule